// File: doc/BRIEF.md
# Memory-Mapped IDE Register Bridge

This block sits between a simple memory-mapped request bus and an IDE disk interface. Each bus request carries an address, a size code, a write flag and write data. The bridge takes a register index from the address, using bits [11:4]. A 4 KiB window therefore holds 256 register slots, 16 bytes apart, and address bits above and below that field play no part. Byte accesses reach the seven task-file registers and the device-control / alternate-status register, which answers at two separate indices. Half-word and word accesses reach only the data port at index 0. Their bytes are reversed in both directions, so a big-endian bus can talk to the little-endian device.

Every device-side strobe is a registered single-cycle pulse. A read strobe is raised one cycle after the request, and the device presents its read data during that cycle. The bridge registers that data, byte-swapped where needed, and returns it one cycle later with a response flag. Reads of slots that map to nothing return all ones at the width of the access, and writes to them have no effect. A reset of the bridge is passed on to the attached drives as a registered reset line.

Top module: `ide_mmio_bridge`

## Requirements
- R1: The register index is bus_addr[11:4]. Address bits [3:0] and those above bit 11 do not change the decode.
- R2: A byte access (size code 0) at index 1 to 7 pulses tf_wr (write) or tf_rd (read) one cycle after the request, with tf_idx equal to the index. A write also carries bus_wdata[7:0] on tf_wdata, and a read returns {24'h0, tf_rdata}.
- R3: A byte access at index 8 or index 22 pulses ctl_wr with ctl_wdata = bus_wdata[7:0] on a write, or pulses alt_rd and returns {24'h0, alt_rdata} on a read.
- R4: A byte access at any other index, index 0 included, raises no strobe. A read there returns 32'h0000_00FF.
- R5: A half-word (size code 1) or word (size code 2) write at index 0 pulses dp_wr. A half-word write sets dp_wide=0 and dp_wdata = {16'h0, bus_wdata[7:0], bus_wdata[15:8]}. A word write sets dp_wide=1 and dp_wdata to bus_wdata with its four bytes reversed.
- R6: A half-word or word read at index 0 pulses dp_rd, with dp_wide set as in R5. A half-word read returns {16'h0, dp_rdata[7:0], dp_rdata[15:8]}. A word read returns dp_rdata with its four bytes reversed.
- R7: A half-word or word access at a nonzero index raises no strobe. A read there returns 32'h0000_FFFF for a half-word and 32'hFFFF_FFFF for a word.
- R8: Device strobes appear exactly one cycle after the request, and at most one is high at a time. rsp_valid is high exactly two cycles after a read request, for one cycle, and never follows a write.
- R9: While rst is high, all strobes and rsp_valid are low. dev_reset is high in the cycle after any cycle with rst high and low in the cycle after rst is low.
- R10: Size code 3 is reserved. It raises no strobe, and a read with it returns 32'hFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned |
| tf_wr | output | 1 | Task-file write pulse |
| tf_rd | output | 1 | Task-file read pulse |
| tf_idx | output | 3 | Task-file register number |
| tf_wdata | output | 8 | Task-file write data |
| tf_rdata | input | 8 | Task-file read data, valid in the tf_rd cycle |
| ctl_wr | output | 1 | Device-control write pulse |
| ctl_wdata | output | 8 | Device-control write data |
| alt_rd | output | 1 | Alternate-status read pulse |
| alt_rdata | input | 8 | Alternate-status value, valid in the alt_rd cycle |
| dp_wr | output | 1 | Data-port write pulse |
| dp_rd | output | 1 | Data-port read pulse |
| dp_wide | output | 1 | 1 = 32-bit data-port transfer, 0 = 16-bit |
| dp_wdata | output | 32 | Data-port write data, device byte order |
| dp_rdata | input | 32 | Data-port read data, device byte order |
| dev_reset | output | 1 | Reset to the attached drives |

## Verification
The hardest case to reach from the ports is the second control alias: index 22 combined with address bits that lie outside the decoded field. A uniformly random address lands on that slot about once in 256 byte accesses. The random stimulus therefore draws the index from a biased set that weights 0, 7, 8, 9, 21, 22, 23 and 255 heavily, and it fills bits [3:0] and [31:12] with random values. Directed accesses with addresses such as 0x0000_1160 and 0xFFFF_F01F also confirm that the decode ignores the bits outside [11:4].

// File: rtl/ide_mmio_pkg.sv
package ide_mmio_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_DATA = 2'd3
  } acc_tgt_e;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode
  import ide_mmio_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int TF_FIRST    = 1,
  parameter int TF_LAST     = 7,
  parameter int CTL_IDX_A   = 8,
  parameter int CTL_IDX_B   = 22,
  parameter int TF_IDX_W    = 3
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          size,
  output acc_tgt_e            tgt,
  output logic [TF_IDX_W-1:0] task_sel
);
  localparam int IDX_W = WIN_BITS - STRIDE_BITS;

  logic [IDX_W-1:0] idx;
  logic             unused_addr_bits;

  assign idx              = addr[WIN_BITS-1:STRIDE_BITS];
  assign task_sel         = idx[TF_IDX_W-1:0];
  assign unused_addr_bits = ^{addr[ADDR_W-1:WIN_BITS], addr[STRIDE_BITS-1:0]};

  always_comb begin
    tgt = TGT_NONE;
    case (size)
      SZ_BYTE: begin
        if (idx >= IDX_W'(TF_FIRST) && idx <= IDX_W'(TF_LAST))
          tgt = TGT_TASK;
        else if (idx == IDX_W'(CTL_IDX_A) || idx == IDX_W'(CTL_IDX_B))
          tgt = TGT_CTRL;
      end
      SZ_HALF, SZ_WORD: begin
        if (idx == '0)
          tgt = TGT_DATA;
      end
      default: tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/ide_byte_swap.sv
module ide_byte_swap #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*8 +: 8] = din[(LANES-1-g)*8 +: 8];
  end
endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
  import ide_mmio_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int CTL_IDX_A   = 8,
  parameter int CTL_IDX_B   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              tf_wr,
  output logic              tf_rd,
  output logic [2:0]        tf_idx,
  output logic [7:0]        tf_wdata,
  input  logic [7:0]        tf_rdata,
  output logic              ctl_wr,
  output logic [7:0]        ctl_wdata,
  output logic              alt_rd,
  input  logic [7:0]        alt_rdata,
  output logic              dp_wr,
  output logic              dp_rd,
  output logic              dp_wide,
  output logic [31:0]       dp_wdata,
  input  logic [31:0]       dp_rdata
  ,output logic             dev_reset
);
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  acc_tgt_e    req_tgt;
  logic [2:0]  req_sel;
  logic [15:0] wr_sw16, rd_sw16;
  logic [31:0] wr_sw32, rd_sw32;
  logic        rd_pend;
  acc_tgt_e    rd_tgt;
  logic [1:0]  rd_size;
  logic [31:0] rd_mux;
  logic        is_rd, is_wr;

  ide_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
    .TF_FIRST(1), .TF_LAST(7), .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B),
    .TF_IDX_W(3)
  ) u_dec (
    .addr(bus_addr), .size(bus_size), .tgt(req_tgt), .task_sel(req_sel)
  );

  ide_byte_swap #(.LANES(HALF_W/8)) u_wr16 (.din(bus_wdata[15:0]), .dout(wr_sw16));
  ide_byte_swap #(.LANES(WORD_W/8)) u_wr32 (.din(bus_wdata),       .dout(wr_sw32));
  ide_byte_swap #(.LANES(HALF_W/8)) u_rd16 (.din(dp_rdata[15:0]),  .dout(rd_sw16));
  ide_byte_swap #(.LANES(WORD_W/8)) u_rd32 (.din(dp_rdata),        .dout(rd_sw32));

  assign is_rd = bus_valid && !bus_write;
  assign is_wr = bus_valid &&  bus_write;

  always_comb begin
    case (rd_tgt)
      TGT_TASK: rd_mux = {24'h0, tf_rdata};
      TGT_CTRL: rd_mux = {24'h0, alt_rdata};
      TGT_DATA: rd_mux = (rd_size == SZ_WORD) ? rd_sw32 : {16'h0, rd_sw16};
      default: begin
        case (rd_size)
          SZ_BYTE: rd_mux = 32'h0000_00FF;
          SZ_HALF: rd_mux = 32'h0000_FFFF;
          default: rd_mux = 32'hFFFF_FFFF;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_reset <= 1'b1;
      tf_wr     <= 1'b0;
      tf_rd     <= 1'b0;
      ctl_wr    <= 1'b0;
      alt_rd    <= 1'b0;
      dp_wr     <= 1'b0;
      dp_rd     <= 1'b0;
      dp_wide   <= 1'b0;
      tf_idx    <= '0;
      tf_wdata  <= '0;
      ctl_wdata <= '0;
      dp_wdata  <= '0;
      rd_pend   <= 1'b0;
      rd_tgt    <= TGT_NONE;
      rd_size   <= SZ_BYTE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      dev_reset <= 1'b0;
      tf_wr     <= is_wr && (req_tgt == TGT_TASK);
      tf_rd     <= is_rd && (req_tgt == TGT_TASK);
      ctl_wr    <= is_wr && (req_tgt == TGT_CTRL);
      alt_rd    <= is_rd && (req_tgt == TGT_CTRL);
      dp_wr     <= is_wr && (req_tgt == TGT_DATA);
      dp_rd     <= is_rd && (req_tgt == TGT_DATA);
      if (bus_valid) begin
        tf_idx    <= req_sel;
        tf_wdata  <= bus_wdata[7:0];
        ctl_wdata <= bus_wdata[7:0];
        dp_wide   <= (bus_size == SZ_WORD);
        dp_wdata  <= (bus_size == SZ_WORD) ? wr_sw32 : {16'h0, wr_sw16};
      end
      rd_pend   <= is_rd;
      rd_tgt    <= req_tgt;
      rd_size   <= bus_size;
      rsp_valid <= rd_pend;
      if (rd_pend)
        rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ide_mmio_bridge_chk.sv
module ide_mmio_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_wdata,
  input logic        rsp_valid,
  input logic        tf_wr,
  input logic        tf_rd,
  input logic [2:0]  tf_idx,
  input logic        ctl_wr,
  input logic        alt_rd,
  input logic        dp_wr,
  input logic        dp_rd,
  input logic        dp_wide,
  input logic [31:0] dp_wdata,
  input logic        dev_reset
);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tf_wr, tf_rd, ctl_wr, alt_rd, dp_wr, dp_rd}));

  p_read_gets_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> ##1 rsp_valid);

  p_rsp_only_after_read_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(bus_valid && !bus_write, 2));

  p_task_idx_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    (tf_wr || tf_rd) |-> (tf_idx != 3'd0));

  p_ctl_from_byte_write_r3: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |-> $past(bus_valid && bus_write && bus_size == 2'd0));

  p_word_swap_r5: assert property (@(posedge clk) disable iff (rst)
    (dp_wr && dp_wide) |-> dp_wdata == {$past(bus_wdata[7:0]), $past(bus_wdata[15:8]),
                                        $past(bus_wdata[23:16]), $past(bus_wdata[31:24])});

  p_rsvd_size_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_size == 2'd3) |=> !(tf_wr || tf_rd || ctl_wr || alt_rd || dp_wr || dp_rd));

  p_dev_reset_r9: assert property (@(posedge clk) rst |=> dev_reset);
endmodule

bind ide_mmio_bridge ide_mmio_bridge_chk u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
  .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_idx(tf_idx), .ctl_wr(ctl_wr),
  .alt_rd(alt_rd), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_wide(dp_wide),
  .dp_wdata(dp_wdata), .dev_reset(dev_reset)
);

// File: tb/test_ide_mmio_bridge.sv
module test_ide_mmio_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        tf_wr, tf_rd, ctl_wr, alt_rd, dp_wr, dp_rd, dp_wide, dev_reset;
  logic [2:0]  tf_idx;
  logic [7:0]  tf_wdata, ctl_wdata, tf_rdata, alt_rdata;
  logic [31:0] dp_wdata, dp_rdata;
  logic [7:0]  alt_val = 8'h5C;
  logic [31:0] dp_val  = 32'h1122_3344;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // simple device model
  assign tf_rdata  = 8'hA0 ^ {5'd0, tf_idx};
  assign alt_rdata = alt_val;
  assign dp_rdata  = dp_val;

  ide_mmio_bridge i_ide_mmio_bridge (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tf_wr(tf_wr), .tf_rd(tf_rd), .tf_idx(tf_idx), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .alt_rd(alt_rd), .alt_rdata(alt_rdata), .dp_wr(dp_wr), .dp_rd(dp_rd),
    .dp_wide(dp_wide), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .dev_reset(dev_reset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // 0 none, 1 task file, 2 control, 3 data port
  function automatic int target_of(input logic [1:0] sz, input logic [31:0] a);
    logic [7:0] ix = a[11:4];
    if (sz == 2'd0) begin
      if (ix >= 8'd1 && ix <= 8'd7) return 1;
      if (ix == 8'd8 || ix == 8'd22) return 2;
      return 0;
    end
    if ((sz == 2'd1 || sz == 2'd2) && ix == 8'd0) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] sz, input logic [31:0] a);
    case (target_of(sz, a))
      1: return {24'h0, 8'hA0 ^ {5'd0, a[6:4]}};
      2: return {24'h0, alt_val};
      3: return (sz == 2'd2) ? rev32(dp_val) : {16'h0, dp_val[7:0], dp_val[15:8]};
      default: return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string req_of(input bit wr, input logic [1:0] sz, input int t);
    if (t == 1) return "R2";
    if (t == 2) return "R3";
    if (t == 3) return wr ? "R5" : "R6";
    if (sz == 2'd0) return "R4";
    if (sz == 2'd3) return "R10";
    return "R7";
  endfunction

  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input string tag);
    int t = target_of(sz, a);
    string rq = (tag != "") ? tag : req_of(wr, sz, t);
    logic [5:0] exp_stb;
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    exp_stb = {wr && t == 1, !wr && t == 1, wr && t == 2, !wr && t == 2, wr && t == 3, !wr && t == 3};
    chk({tf_wr, tf_rd, ctl_wr, alt_rd, dp_wr, dp_rd} == exp_stb, rq, "strobes",
        {26'h0, tf_wr, tf_rd, ctl_wr, alt_rd, dp_wr, dp_rd}, {26'h0, exp_stb});
    if (t == 1)
      chk(tf_idx == a[6:4] && (!wr || tf_wdata == wd[7:0]), rq, "task fields",
          {21'h0, tf_idx, tf_wdata}, {21'h0, a[6:4], wr ? wd[7:0] : tf_wdata});
    if (t == 2 && wr)
      chk(ctl_wdata == wd[7:0], rq, "ctl data", {24'h0, ctl_wdata}, {24'h0, wd[7:0]});
    if (t == 3) begin
      chk(dp_wide == (sz == 2'd2), rq, "dp width", {31'h0, dp_wide}, {31'h0, sz == 2'd2});
      if (wr)
        chk(dp_wdata == ((sz == 2'd2) ? rev32(wd) : {16'h0, wd[7:0], wd[15:8]}), rq,
            "dp wdata", dp_wdata, (sz == 2'd2) ? rev32(wd) : {16'h0, wd[7:0], wd[15:8]});
    end
    chk(rsp_valid == 1'b0, "R8", "early rsp", {31'h0, rsp_valid}, 32'h0);
    exp_rd = exp_read(sz, a);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == !wr, "R8", "rsp timing", {31'h0, rsp_valid}, {31'h0, !wr});
    if (!wr) chk(rsp_rdata == exp_rd, rq, "read data", rsp_rdata, exp_rd);
  endtask

  function automatic logic [7:0] pick_idx();
    int r = $urandom_range(0, 11);
    case (r)
      0: return 8'd0;  1: return 8'd7;  2: return 8'd8;   3: return 8'd9;
      4: return 8'd21; 5: return 8'd22; 6: return 8'd23;  7: return 8'd255;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D3));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dev_reset == 1'b1, "R9", "dev_reset in reset", {31'h0, dev_reset}, 32'h1);
    chk({rsp_valid, tf_wr, tf_rd, ctl_wr, alt_rd, dp_wr, dp_rd} == 7'h0, "R9",
        "quiet in reset", {25'h0, rsp_valid, tf_wr, tf_rd, ctl_wr, alt_rd, dp_wr, dp_rd}, 32'h0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(dev_reset == 1'b0, "R9", "dev_reset released", {31'h0, dev_reset}, 32'h0);

    for (int i = 1; i <= 7; i++) begin
      access(1'b1, 2'd0, 32'(i) << 4, 32'hC0 + 32'(i), "");
      access(1'b0, 2'd0, 32'(i) << 4, 32'h0, "");
    end
    access(1'b1, 2'd0, 32'h80, 32'h0000_0006, "");
    access(1'b0, 2'd0, 32'h160, 32'h0, "");
    access(1'b1, 2'd0, 32'h0000_1160, 32'h0000_0002, "R1");
    access(1'b1, 2'd0, 32'hFFFF_F01F, 32'h0000_00E5, "R1");
    access(1'b0, 2'd0, 32'h0000_0000, 32'h0, "");
    access(1'b0, 2'd0, 32'h0000_0090, 32'h0, "");
    access(1'b1, 2'd0, 32'h0000_0150, 32'h55, "");
    access(1'b0, 2'd0, 32'h0000_0FF0, 32'h0, "");
    access(1'b1, 2'd1, 32'h0, 32'hDEAD_BEEF, "");
    access(1'b1, 2'd2, 32'h0, 32'h0102_0304, "");
    access(1'b0, 2'd1, 32'h0, 32'h0, "");
    access(1'b0, 2'd2, 32'hABCD_E00C, 32'h0, "R1");
    access(1'b0, 2'd1, 32'h10, 32'h0, "");
    access(1'b1, 2'd2, 32'h80, 32'hFFFF_0000, "");
    access(1'b0, 2'd2, 32'h160, 32'h0, "");
    access(1'b0, 2'd3, 32'h0, 32'h0, "");
    access(1'b1, 2'd3, 32'h10, 32'h12, "");

    // reset pulse in mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(dev_reset == 1'b1, "R9", "dev_reset mid-run", {31'h0, dev_reset}, 32'h1);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(dev_reset == 1'b0, "R9", "dev_reset drop", {31'h0, dev_reset}, 32'h0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      alt_val = 8'($urandom);
      dp_val  = $urandom;
      a = {20'($urandom), pick_idx(), 4'($urandom)};
      access(1'($urandom), 2'($urandom_range(0, 3)), a, $urandom, "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule